// File: doc/BRIEF.md
# Oversampled SPI Mode-0 Frame Receiver

This block is a receive-only SPI target that lives entirely in the system clock domain. The serial clock, the data line from the controller and the active-low select line enter as asynchronous pins. Each one is shifted into a short history register on every system clock. Edges of the serial clock and of the select line are decoded from the two oldest history bits. No pin ever clocks a flop.

A falling edge on select opens a frame. Each rising edge of the serial clock then shifts one data bit into the low end of an assembly register, so the most significant bit arrives first. After the sixteenth rising edge, the block presents the assembled word and pulses a done flag for one system clock. It then ignores the serial clock until the next frame opens. A rising edge on select closes the frame at any point. A frame closed before its last bit is dropped.

The system clock must run several times faster than the serial clock, so that each level on the pins lasts at least two system clocks.

Top module: `spi_m0_rx`

## Requirements
- R1: During and after reset, with select high, `frame_done` is 0 and `frame_word` is 0.
- R2: Within one select-low window, the first 16 rising edges of `sck_in` each capture `mosi_in`. The first captured bit becomes bit 15 of `frame_word` and the last becomes bit 0. The word appears together with `frame_done`.
- R3: `frame_done` is high for exactly one system clock per completed frame.
- R4: `frame_word` changes only in the cycle where `frame_done` is high. Otherwise it keeps the last completed word.
- R5: While `csn_in` is high, activity on `sck_in` and `mosi_in` produces no `frame_done` and leaves `frame_word` unchanged.
- R6: If `csn_in` rises before the 16th rising edge, there is no `frame_done` and `frame_word` keeps its old value. The next select-low window assembles a fresh word from its own first 16 bits.
- R7: Rising edges of `sck_in` after the 16th, within the same select-low window, are ignored. There is no second `frame_done` and `frame_word` holds the first 16 bits.
- R8: Data is captured only on rising edges of `sck_in` (clock polarity 0, phase 0). The value of `mosi_in` is taken from the same system clock sample in which `sck_in` is first seen high. Changes on `mosi_in` two or more system clocks after that sample have no effect on the captured bit.
- R9: Assume the final rising edge of `sck_in` is first sampled high at system clock edge k, with the default three-stage history. Then `frame_done` and the new `frame_word` appear after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sck_in` |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_in | input | 1 | Serial clock from the controller, asynchronous |
| mosi_in | input | 1 | Serial data from the controller, asynchronous |
| csn_in | input | 1 | Active-low frame select, asynchronous |
| frame_word | output | 16 | Last completed 16-bit word, first received bit in bit 15 |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The embedded properties check the following on every cycle:
- `frame_done` never lasts two cycles.
- `frame_word` moves only alongside `frame_done`.
- The bit counter stays within the frame length.
- A select rising edge always clears the counter without completing a frame.
- Once select is seen steadily high, no completion can follow.

Some behaviours can only be shown by the bench's directed scenarios, because they need the serial stimulus and a value worked out independently:
- The bit order of assembled words.
- Rejection of extra and truncated bits.
- MOSI sampled in step with the delayed clock edge rather than the raw pin.
- The exact two-cycle latency from the final sampled edge.

// File: rtl/spi_m0_rx.sv
module spi_m0_rx #(
  parameter int FRAME_BITS = 16,
  parameter int SYNC_DEPTH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_in,
  input  logic                  mosi_in,
  input  logic                  csn_in,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  frame_done
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int OLD   = SYNC_DEPTH - 1;
  localparam int NEW   = SYNC_DEPTH - 2;

  logic [SYNC_DEPTH-1:0] sck_h, mosi_h, cs_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_h  <= '0;
      mosi_h <= '0;
      cs_h   <= '1;
    end else begin
      sck_h  <= {sck_h[SYNC_DEPTH-2:0], sck_in};
      mosi_h <= {mosi_h[SYNC_DEPTH-2:0], mosi_in};
      cs_h   <= {cs_h[SYNC_DEPTH-2:0], csn_in};
    end
  end

  wire sck_rise = ~sck_h[OLD] & sck_h[NEW];
  wire cs_rise  = ~cs_h[OLD] & cs_h[NEW];
  wire cs_fall  = cs_h[OLD] & ~cs_h[NEW];
  wire mosi_s   = mosi_h[NEW];

  logic                  listening;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;

  wire                  take     = listening & sck_rise & ~cs_rise & ~cs_fall;
  wire                  last_bit = (bit_cnt == CNT_W'(FRAME_BITS - 1));
  wire [FRAME_BITS-1:0] shreg_nx = {shreg[FRAME_BITS-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      listening  <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_word <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (cs_rise) begin
        listening <= 1'b0;
        bit_cnt   <= '0;
      end else if (cs_fall) begin
        listening <= 1'b1;
        bit_cnt   <= '0;
      end else if (take) begin
        shreg   <= shreg_nx;
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          listening  <= 1'b0;
          frame_word <= shreg_nx;
          frame_done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_word));

  assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_h[OLD] & cs_h[NEW]) |=> !frame_done);

  assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bit_cnt == '0) && !frame_done);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));

  assert_done_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_cnt == CNT_W'(FRAME_BITS)) && !listening);

endmodule

// File: tb/spi_m0_rx_tb.sv
module spi_m0_rx_tb_top;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic [15:0] frame_word;
  logic frame_done;

  int checks = 0, errors = 0;
  int done_cnt = 0, double_cnt = 0, glitch_cnt = 0;
  logic prev_done = 1'b0;
  logic [15:0] prev_word = '0;

  always #5 clk = ~clk;

  spi_m0_rx dut_i (.clk(clk), .rst_n(rst_n), .sck_in(sck), .mosi_in(mosi),
                   .csn_in(csn), .frame_word(frame_word), .frame_done(frame_done));

  always @(negedge clk) if (rst_n) begin
    if (frame_done) begin
      done_cnt++;
      if (prev_done) double_cnt++;
    end else if (frame_word !== prev_word) glitch_cnt++;
    prev_done = frame_done;
    prev_word = frame_word;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] data, int n, bit late_flip);
    for (int b = n - 1; b >= 0; b--) begin
      mosi = data[b];
      sck = 1'b0;
      wait_n(HP);
      sck = 1'b1;
      if (late_flip) begin
        wait_n(2);
        mosi = ~data[b];
        wait_n(HP - 2);
      end else wait_n(HP);
    end
    sck = 1'b0;
    wait_n(HP);
  endtask

  task automatic frame(logic [31:0] data, int n, bit late_flip);
    csn = 1'b0;
    wait_n(HP);
    send_bits(data, n, late_flip);
    csn = 1'b1;
    wait_n(2 * HP);
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, frame_done}, 32'd0);
    check("R1 word", {16'd0, frame_word}, 32'd0);
  endtask

  task automatic t_basic();
    int d0 = done_cnt;
    frame(32'hA5C3, 16, 1'b0);
    check("R2 word A5C3", {16'd0, frame_word}, 32'h0000A5C3);
    check("R3 one done", d0 + 1, done_cnt);
    d0 = done_cnt;
    frame(32'h0001, 16, 1'b0);
    check("R2 word 0001", {16'd0, frame_word}, 32'h00000001);
    frame(32'h8000, 16, 1'b0);
    check("R2 word 8000", {16'd0, frame_word}, 32'h00008000);
    check("R3 two done", d0 + 2, done_cnt);
  endtask

  task automatic t_cs_high();
    int d0 = done_cnt;
    logic [15:0] w0 = frame_word;
    csn = 1'b1;
    send_bits(32'h1234, 16, 1'b0);
    send_bits(32'hFFFF, 16, 1'b0);
    check("R5 no done", done_cnt, d0);
    check("R5 word kept", {16'd0, frame_word}, {16'd0, w0});
  endtask

  task automatic t_truncated();
    int d0 = done_cnt;
    logic [15:0] w0 = frame_word;
    frame(32'h3FF, 10, 1'b0);
    check("R6 no done", done_cnt, d0);
    check("R6 word kept", {16'd0, frame_word}, {16'd0, w0});
    frame(32'h5A96, 16, 1'b0);
    check("R6 fresh word", {16'd0, frame_word}, 32'h00005A96);
  endtask

  task automatic t_extra();
    int d0 = done_cnt;
    frame(32'h000C_3E7F, 20, 1'b0);
    check("R7 first 16 bits", {16'd0, frame_word}, 32'h0000C3E7);
    check("R7 single done", done_cnt, d0 + 1);
  endtask

  task automatic t_late_flip();
    frame(32'hB2D4, 16, 1'b1);
    check("R8 word B2D4", {16'd0, frame_word}, 32'h0000B2D4);
    frame(32'h4D2B, 16, 1'b1);
    check("R8 word 4D2B", {16'd0, frame_word}, 32'h00004D2B);
  endtask

  task automatic t_latency();
    csn = 1'b0;
    wait_n(HP);
    send_bits(32'h7E81 >> 1, 15, 1'b0);
    mosi = 1'b1;
    sck = 1'b0;
    wait_n(HP);
    sck = 1'b1;
    wait_n(2);
    check("R9 not early", {31'd0, frame_done}, 32'd0);
    wait_n(1);
    check("R9 done on time", {31'd0, frame_done}, 32'd1);
    check("R9 word on time", {16'd0, frame_word}, 32'h00007E81);
    wait_n(HP);
    sck = 1'b0;
    wait_n(HP);
    csn = 1'b1;
    wait_n(2 * HP);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(5);
    t_reset();
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_basic();
    t_cs_high();
    t_truncated();
    t_extra();
    t_late_flip();
    t_latency();
    check("R3 no wide pulse", double_cnt, 0);
    check("R4 no stray word change", glitch_cnt, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule